// File: doc/BRIEF.md
# Dual-Multiplier Multiply-Accumulate Slice

This block is a fixed-point arithmetic tile with two signed 18x19 multipliers, a top one and a bottom one. A build-time parameter picks how their products are used. In split mode each product comes out on its own. In sum mode the two products are added or differenced, the result is added to or subtracted from a 64-bit chain input, and an optional feedback term is added on top. That term is either the previous output or a fixed power of two. Every data path and control input passes through three register stages (input, pipeline, output), so a result always leaves exactly three clock edges after its operands enter.

Each half can put a pre-adder in front of its multiplier, which sums the y and z operands. It can also replace its x operand with one of eight coefficients that are fixed as parameters. The coefficient is chosen each cycle by a 3-bit select. Slices are tiled through two cascades. The scan port carries the registered top x operand to the next slice, and that slice can take it in place of its own top x input. The chain port carries the full 64-bit result to the next slice's chain input. Each register stage has its own clock enable. The input stage has one active-low synchronous clear, and the pipeline and output stages share a second one.

Top module: `dsp_slice`

## Requirements
- R1: When both clears are low at a clock edge, res_a, res_b, chain_out and scan_out are all zero afterwards.
- R2: In sum mode, res_a equals chain_in + P, where P is top product + bottom product when op_sub is 0 and top product - bottom product when op_sub is 1. All operands are taken from the inputs three edges earlier.
- R3: In split mode, res_a is the top product sign-extended to 64 bits, and res_b is the 37-bit bottom product, both after three edges. In sum mode res_b stays zero.
- R4: In sum mode with op_neg at 1, the product term P is subtracted from chain_in instead of added.
- R5: In sum mode with op_acc at 1 and op_ld at 0, the previous res_a is added to the new result. All sums wrap modulo 2^64 with no saturation.
- R6: In sum mode with op_ld at 1, the value 2^LC_SHIFT is added in place of any feedback. This holds even when op_acc is also 1.
- R7: With the pre-adder enabled, each multiplier's y operand is y + z, with z sign-extended and the sum wrapped to 19 bits.
- R8: With coefficients enabled, each multiplier's x operand is coefficient entry sel of its table, with entry i at bits [18i+17:18i]. The select is registered together with the data it goes with.
- R9: scan_out is the top x input as captured by the input register, one edge after it is driven. With SCAN_SRC set, the top x input register loads from scan_in instead of top_x.
- R10: When a stage's enable is low, that stage holds its contents. With en_out low, res_a does not change. With en_in low, scan_out does not change.
- R11: A low rst_pipe_n clears res_a and res_b and leaves the input registers, and therefore scan_out, unchanged.
- R12: chain_out always equals res_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst_in_n | input | 1 | Synchronous active-low clear of the input stage |
| rst_pipe_n | input | 1 | Synchronous active-low clear of the pipeline and output stages |
| en_in | input | 1 | Input stage enable |
| en_pipe | input | 1 | Pipeline stage enable |
| en_out | input | 1 | Output stage enable |
| top_x | input | XW | Top multiplier x operand |
| top_y | input | YW | Top multiplier y operand, or the pre-adder's first term |
| top_z | input | ZW | Top pre-adder second term |
| bot_x | input | XW | Bottom multiplier x operand |
| bot_y | input | YW | Bottom multiplier y operand, or the pre-adder's first term |
| bot_z | input | ZW | Bottom pre-adder second term |
| top_sel | input | SELW | Top coefficient select |
| bot_sel | input | SELW | Bottom coefficient select |
| op_sub | input | 1 | 1: subtract the bottom product from the top product |
| op_neg | input | 1 | 1: subtract the product term from the chain input |
| op_acc | input | 1 | 1: add the previous result |
| op_ld | input | 1 | 1: add the load constant (overrides op_acc) |
| scan_in | input | XW | Top x operand from the previous slice |
| scan_out | output | XW | Registered top x operand for the next slice |
| chain_in | input | OW | Result from the previous slice |
| chain_out | output | OW | Result for the next slice |
| res_a | output | OW | Main result |
| res_b | output | XW+YW | Bottom product in split mode, zero otherwise |

## Verification
The hardest situations to reach are the ones that depend on history. One is feedback that crosses the 64-bit wrap. Another is the load constant winning over accumulate. A third is two cascaded slices whose scan data is one cycle apart. The bench streams operands every cycle without gaps, so each result depends on the one before it. Its model carries the previous expected result forward to match. A load with LC_SHIFT at 63 followed by an accumulate of 2^63 from the chain must give exactly zero. A second slice in split mode takes its top operand from the first slice's scan output, and the model delays that operand by one item. Stage holds and the split clear are exercised last, with directed enable and clear patterns.

// File: rtl/dsp_slice_pkg.sv
// Shared types for the multiply-accumulate slice.
// Assumes: nothing beyond IEEE 1800-2017.
package dsp_slice_pkg;

    // Build-time choice of how the two products are used.
    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_SUM   = 1'b1
    } mode_e;

    // Runtime controls travelling with the data through the stages.
    typedef struct packed {
        logic sub;
        logic neg;
        logic acc;
        logic ld;
    } ctl_t;

endpackage

// File: rtl/dsp_half.sv
// One multiplier half: input register, optional pre-adder, optional
// coefficient table, and the pipeline register holding the product.
// Assumes: coefficient entry i sits at COEFS[i*XW +: XW]; all operands
// are two's complement.
module dsp_half #(
    parameter int XW       = 18,
    parameter int YW       = 19,
    parameter int ZW       = 18,
    parameter int NCOEF    = 8,
    parameter bit PRE_ADD  = 1'b0,
    parameter bit COEF_EN  = 1'b0,
    parameter bit USE_SCAN = 1'b0,
    parameter logic [NCOEF*XW-1:0] COEFS = '0,
    localparam int SELW = $clog2(NCOEF),
    localparam int PW   = XW + YW
) (
    input  logic                 clk,
    input  logic                 rst_in_n,
    input  logic                 rst_pipe_n,
    input  logic                 en_in,
    input  logic                 en_pipe,
    input  logic [XW-1:0]        x_in,
    input  logic [XW-1:0]        scan_in,
    input  logic [YW-1:0]        y_in,
    input  logic [ZW-1:0]        z_in,
    input  logic [SELW-1:0]      sel_in,
    output logic [XW-1:0]        x_reg,
    output logic signed [PW-1:0] prod
);

    logic [XW-1:0]        x_q;
    logic signed [YW-1:0] y_q;
    logic signed [XW-1:0] mult_x;
    logic signed [YW-1:0] mult_y;
    logic [XW-1:0]        x_src;

    // Pick the raw x source: own input or the previous slice's scan bus.
    generate
        if (USE_SCAN) begin : g_scan
            logic unused_x;
            assign unused_x = ^x_in;
            assign x_src    = scan_in;
        end else begin : g_direct
            logic unused_scan;
            assign unused_scan = ^scan_in;
            assign x_src       = x_in;
        end
    endgenerate

    // Input stage: capture x and y.
    always_ff @(posedge clk) begin
        if (!rst_in_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (en_in) begin
            x_q <= x_src;
            y_q <= y_in;
        end
    end

    assign x_reg = x_q;

    // Pre-adder variant: register z and fold it into y with wrap.
    generate
        if (PRE_ADD) begin : g_pre
            logic signed [ZW-1:0] z_q;
            // Input stage: capture the pre-adder term.
            always_ff @(posedge clk) begin
                if (!rst_in_n)  z_q <= '0;
                else if (en_in) z_q <= z_in;
            end
            assign mult_y = y_q + YW'(z_q);
        end else begin : g_nopre
            logic unused_z;
            assign unused_z = ^z_in;
            assign mult_y   = y_q;
        end
    endgenerate

    // Coefficient variant: a registered select picks a table entry.
    generate
        if (COEF_EN) begin : g_coef
            logic [SELW-1:0] sel_q;
            // Input stage: capture the select with its data.
            always_ff @(posedge clk) begin
                if (!rst_in_n)  sel_q <= '0;
                else if (en_in) sel_q <= sel_in;
            end
            assign mult_x = COEFS[sel_q*XW +: XW];
        end else begin : g_nocoef
            logic unused_sel;
            assign unused_sel = ^sel_in;
            assign mult_x     = x_q;
        end
    endgenerate

    // Pipeline stage: register the exact signed product.
    always_ff @(posedge clk) begin
        if (!rst_pipe_n)  prod <= '0;
        else if (en_pipe) prod <= PW'(mult_x) * PW'(mult_y);
    end

    // R10: a disabled input stage keeps its operand.
    p_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_in_n)
        !en_in |=> $stable(x_q));

endmodule

// File: rtl/dsp_out_stage.sv
// Output stage: in sum mode combines the products with the chain input
// and the feedback or load constant; in split mode registers the two
// products separately.
// Assumes: inputs are already aligned by the pipeline stage.
module dsp_out_stage
    import dsp_slice_pkg::*;
#(
    parameter int    OW       = 64,
    parameter int    PW       = 37,
    parameter mode_e MODE     = MODE_SUM,
    parameter int    LC_SHIFT = 16,
    localparam logic [OW-1:0] LC_VAL = OW'(1) << LC_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [PW-1:0] p_top,
    input  logic signed [PW-1:0] p_bot,
    input  logic [OW-1:0]        chain,
    input  ctl_t                 ctl,
    output logic [OW-1:0]        res_a,
    output logic [PW-1:0]        res_b
);

    generate
        if (MODE == MODE_SUM) begin : g_sum
            logic signed [OW-1:0] pair;
            logic signed [OW-1:0] term;
            logic [OW-1:0]        base;
            logic [OW-1:0]        acc_q;

            // Form the product term and the feedback term.
            always_comb begin
                pair = ctl.sub ? (OW'(p_top) - OW'(p_bot))
                               : (OW'(p_top) + OW'(p_bot));
                term = ctl.neg ? -pair : pair;
                if (ctl.ld)       base = LC_VAL;
                else if (ctl.acc) base = acc_q;
                else              base = '0;
            end

            // Output stage: wrap-around 64-bit sum.
            always_ff @(posedge clk) begin
                if (!rst_n)  acc_q <= '0;
                else if (en) acc_q <= chain + base + OW'(term);
            end

            assign res_a = acc_q;
            assign res_b = '0;

            // R5: accumulating a zero term leaves the result unchanged.
            p_accum_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (en && ctl.acc && !ctl.ld && chain == '0 && pair == '0)
                |=> $stable(acc_q));
        end else begin : g_split
            logic [OW-1:0] a_q;
            logic [PW-1:0] b_q;
            logic          unused_ctl;
            assign unused_ctl = ^{chain, ctl};

            // Output stage: register both products on their own.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q <= '0;
                    b_q <= '0;
                end else if (en) begin
                    a_q <= OW'(p_top);
                    b_q <= p_bot;
                end
            end

            assign res_a = a_q;
            assign res_b = b_q;
        end
    endgenerate

    // R10: a disabled output stage holds its result.
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(res_a));

endmodule

// File: rtl/dsp_slice.sv
// Top of the multiply-accumulate slice: two multiplier halves, the
// control and chain pipeline, and the output stage.
// Assumes: three-edge latency from any input to res_a/res_b.
module dsp_slice
    import dsp_slice_pkg::*;
#(
    parameter int    XW       = 18,
    parameter int    YW       = 19,
    parameter int    ZW       = 18,
    parameter int    OW       = 64,
    parameter int    NCOEF    = 8,
    parameter mode_e MODE     = MODE_SUM,
    parameter bit    PRE_ADD  = 1'b0,
    parameter bit    COEF_EN  = 1'b0,
    parameter bit    SCAN_SRC = 1'b0,
    parameter int    LC_SHIFT = 16,
    parameter logic [NCOEF*XW-1:0] COEF_A = {18'd8, 18'd7, 18'd6, 18'd5,
                                             18'd4, 18'd3, 18'd2, 18'd1},
    parameter logic [NCOEF*XW-1:0] COEF_B = {18'd8, 18'd7, 18'd6, 18'd5,
                                             18'd4, 18'd3, 18'd2, 18'd1},
    localparam int SELW = $clog2(NCOEF),
    localparam int PW   = XW + YW
) (
    input  logic            clk,
    input  logic            rst_in_n,
    input  logic            rst_pipe_n,
    input  logic            en_in,
    input  logic            en_pipe,
    input  logic            en_out,
    input  logic [XW-1:0]   top_x,
    input  logic [YW-1:0]   top_y,
    input  logic [ZW-1:0]   top_z,
    input  logic [XW-1:0]   bot_x,
    input  logic [YW-1:0]   bot_y,
    input  logic [ZW-1:0]   bot_z,
    input  logic [SELW-1:0] top_sel,
    input  logic [SELW-1:0] bot_sel,
    input  logic            op_sub,
    input  logic            op_neg,
    input  logic            op_acc,
    input  logic            op_ld,
    input  logic [XW-1:0]   scan_in,
    output logic [XW-1:0]   scan_out,
    input  logic [OW-1:0]   chain_in,
    output logic [OW-1:0]   chain_out,
    output logic [OW-1:0]   res_a,
    output logic [PW-1:0]   res_b
);

    logic signed [PW-1:0] p_top;
    logic signed [PW-1:0] p_bot;
    logic [XW-1:0]        bot_x_reg;
    ctl_t                 ctl_s1, ctl_s2;
    logic [OW-1:0]        chain_s1, chain_s2;
    logic                 unused_bot;

    assign unused_bot = ^bot_x_reg;

    dsp_half #(
        .XW(XW), .YW(YW), .ZW(ZW), .NCOEF(NCOEF), .PRE_ADD(PRE_ADD),
        .COEF_EN(COEF_EN), .USE_SCAN(SCAN_SRC), .COEFS(COEF_A)
    ) u_top (
        .clk(clk), .rst_in_n(rst_in_n), .rst_pipe_n(rst_pipe_n),
        .en_in(en_in), .en_pipe(en_pipe), .x_in(top_x), .scan_in(scan_in),
        .y_in(top_y), .z_in(top_z), .sel_in(top_sel),
        .x_reg(scan_out), .prod(p_top)
    );

    dsp_half #(
        .XW(XW), .YW(YW), .ZW(ZW), .NCOEF(NCOEF), .PRE_ADD(PRE_ADD),
        .COEF_EN(COEF_EN), .USE_SCAN(1'b0), .COEFS(COEF_B)
    ) u_bot (
        .clk(clk), .rst_in_n(rst_in_n), .rst_pipe_n(rst_pipe_n),
        .en_in(en_in), .en_pipe(en_pipe), .x_in(bot_x), .scan_in('0),
        .y_in(bot_y), .z_in(bot_z), .sel_in(bot_sel),
        .x_reg(bot_x_reg), .prod(p_bot)
    );

    // Input stage: capture controls and chain alongside the operands.
    always_ff @(posedge clk) begin
        if (!rst_in_n) begin
            ctl_s1   <= '0;
            chain_s1 <= '0;
        end else if (en_in) begin
            ctl_s1   <= '{sub: op_sub, neg: op_neg, acc: op_acc, ld: op_ld};
            chain_s1 <= chain_in;
        end
    end

    // Pipeline stage: keep controls and chain level with the products.
    always_ff @(posedge clk) begin
        if (!rst_pipe_n) begin
            ctl_s2   <= '0;
            chain_s2 <= '0;
        end else if (en_pipe) begin
            ctl_s2   <= ctl_s1;
            chain_s2 <= chain_s1;
        end
    end

    dsp_out_stage #(
        .OW(OW), .PW(PW), .MODE(MODE), .LC_SHIFT(LC_SHIFT)
    ) u_out (
        .clk(clk), .rst_n(rst_pipe_n), .en(en_out),
        .p_top(p_top), .p_bot(p_bot), .chain(chain_s2), .ctl(ctl_s2),
        .res_a(res_a), .res_b(res_b)
    );

    assign chain_out = res_a;

    // R11: the pipeline clear empties both result ports.
    p_pipe_clear_r11: assert property (@(posedge clk) disable iff (!rst_in_n)
        !rst_pipe_n |=> (res_a == '0 && res_b == '0));

    // R9: the scan bus shows the top operand one edge after it is driven.
    generate
        if (!SCAN_SRC) begin : g_scan_chk
            p_scan_r9: assert property (@(posedge clk) disable iff (!rst_in_n)
                en_in |=> scan_out == $past(top_x));
        end
    endgenerate

endmodule

// File: tb/tb_dsp_slice.sv
// Scoreboard bench: a sum-mode slice (pre-adder and coefficients on)
// feeds its scan bus into a split-mode slice.
module tb_dsp_slice;
    import dsp_slice_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [8*18-1:0] CA = {18'h20000, 18'd131071, 18'd1000, 18'h3FFF9,
                                      18'd100, 18'd3, 18'h3FFFF, 18'd1};
    localparam logic [8*18-1:0] CB = {18'h3FFFF, 18'd4096, 18'd9, 18'h3FF9C,
                                      18'd17, 18'h3FFFD, 18'd5, 18'd2};

    logic clk = 1'b0;
    logic rst_in_n = 1'b0, rst_pipe_n = 1'b0;
    logic en_in = 1'b1, en_pipe = 1'b1, en_out = 1'b1;
    logic [17:0] top_x = '0, top_z = '0, bot_x = '0, bot_z = '0;
    logic [18:0] top_y = '0, bot_y = '0;
    logic [2:0]  top_sel = '0, bot_sel = '0;
    logic op_sub = 0, op_neg = 0, op_acc = 0, op_ld = 0;
    logic [63:0] chain_in = '0;
    logic [17:0] scan_a, scan_f;
    logic [63:0] chain_a, res_a, chain_f, res_fa;
    logic [36:0] res_b, res_fb;

    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        int          due;
        string       tag;
        logic [63:0] ea;
        logic [63:0] fa;
        logic [36:0] fb;
    } item_t;
    item_t sb[$];

    logic [63:0] prev_res = '0;
    logic [17:0] prev_ax  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsp_slice #(.MODE(MODE_SUM), .PRE_ADD(1'b1), .COEF_EN(1'b1), .SCAN_SRC(1'b0),
                .LC_SHIFT(63), .COEF_A(CA), .COEF_B(CB)) dut (
        .clk(clk), .rst_in_n(rst_in_n), .rst_pipe_n(rst_pipe_n),
        .en_in(en_in), .en_pipe(en_pipe), .en_out(en_out),
        .top_x(top_x), .top_y(top_y), .top_z(top_z),
        .bot_x(bot_x), .bot_y(bot_y), .bot_z(bot_z),
        .top_sel(top_sel), .bot_sel(bot_sel),
        .op_sub(op_sub), .op_neg(op_neg), .op_acc(op_acc), .op_ld(op_ld),
        .scan_in('0), .scan_out(scan_a), .chain_in(chain_in),
        .chain_out(chain_a), .res_a(res_a), .res_b(res_b));

    dsp_slice #(.MODE(MODE_SPLIT), .PRE_ADD(1'b0), .COEF_EN(1'b0),
                .SCAN_SRC(1'b1)) dut_f (
        .clk(clk), .rst_in_n(rst_in_n), .rst_pipe_n(rst_pipe_n),
        .en_in(en_in), .en_pipe(en_pipe), .en_out(en_out),
        .top_x(top_x), .top_y(top_y), .top_z(top_z),
        .bot_x(bot_x), .bot_y(bot_y), .bot_z(bot_z),
        .top_sel(top_sel), .bot_sel(bot_sel),
        .op_sub(op_sub), .op_neg(op_neg), .op_acc(op_acc), .op_ld(op_ld),
        .scan_in(scan_a), .scan_out(scan_f), .chain_in(chain_in),
        .chain_out(chain_f), .res_a(res_fa), .res_b(res_fb));

    function automatic longint sx(input longint v, input int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one operand set and push its expected results.
    task automatic drive(input logic [17:0] ax, input logic [18:0] ay, input logic [17:0] az,
                         input logic [17:0] bx, input logic [18:0] by, input logic [17:0] bz,
                         input logic [2:0] sa, input logic [2:0] sbs,
                         input bit sub, input bit neg, input bit acc, input bit ld,
                         input logic [63:0] ch, input string tag);
        longint pt, pb, s, v, ft;
        logic [63:0] base, e;
        item_t it;
        @(negedge clk);
        top_x = ax; top_y = ay; top_z = az; bot_x = bx; bot_y = by; bot_z = bz;
        top_sel = sa; bot_sel = sbs; op_sub = sub; op_neg = neg;
        op_acc = acc; op_ld = ld; chain_in = ch;
        pt = sx(longint'(CA[sa*18 +: 18]), 18) * sx(longint'(ay) + sx(longint'(az), 18), 19);
        pb = sx(longint'(CB[sbs*18 +: 18]), 18) * sx(longint'(by) + sx(longint'(bz), 18), 19);
        s = sub ? pt - pb : pt + pb;
        v = neg ? -s : s;
        base = ld ? (64'd1 << 63) : (acc ? prev_res : 64'd0);
        e = ch + base + 64'(v);
        prev_res = e;
        ft = sx(longint'(prev_ax), 18) * sx(longint'(ay), 19);
        it.due = cyc + 3; it.tag = tag; it.ea = e; it.fa = 64'(ft);
        it.fb = 37'(sx(longint'(bx), 18) * sx(longint'(by), 19));
        prev_ax = ax;
        sb.push_back(it);
    endtask

    // Monitor: pop items as their results emerge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            chk(res_a == it.ea, it.tag, res_a, it.ea);
            chk(res_b == '0, "R3 sum-mode res_b", 64'(res_b), 64'd0);
            chk(chain_a == res_a, "R12 chain_out", chain_a, res_a);
            chk(res_fa == it.fa, "R3/R9 split top via scan", res_fa, it.fa);
            chk(res_fb == it.fb, "R3 split bottom", 64'(res_fb), 64'(it.fb));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(res_a == '0 && res_b == '0, "R1 reset res", res_a, 64'd0);
        chk(chain_a == '0 && scan_a == '0, "R1 reset cascade", chain_a, 64'd0);
        chk(res_fa == '0 && res_fb == '0, "R1 reset split", res_fa, 64'd0);
        rst_in_n = 1'b1; rst_pipe_n = 1'b1;
        repeat (3) @(negedge clk);

        drive(18'd11, 19'd3, 18'd0, 18'd4, 19'd5, 18'd0, 3'd2, 3'd1, 0, 0, 0, 0, 64'd0, "R2 add");
        drive(18'd7, 19'd40, 18'd2, 18'd9, 19'd6, 18'd1, 3'd3, 3'd3, 1, 0, 0, 0, 64'd50, "R2 sub");
        drive(18'h3FFF0, 19'd8, 18'd0, 18'd3, 19'd2, 18'd0, 3'd4, 3'd0, 0, 1, 0, 0, 64'd1000, "R4 negate");
        drive(18'd5, 19'd12, 18'd1, 18'd2, 19'd7, 18'd0, 3'd0, 3'd1, 0, 0, 1, 0, 64'd3, "R5 accumulate");
        drive(18'd6, 19'h7FFF0, 18'd2, 18'd1, 19'd9, 18'd0, 3'd5, 3'd4, 1, 0, 1, 0, 64'd0, "R5 accumulate 2");
        drive(18'd0, 19'd0, 18'd0, 18'd0, 19'd0, 18'd0, 3'd0, 3'd0, 0, 0, 1, 1, 64'd0, "R6 load over acc");
        drive(18'd0, 19'd0, 18'd0, 18'd0, 19'd0, 18'd0, 3'd0, 3'd0, 0, 0, 1, 0, 64'h8000000000000000, "R5 wrap to zero");
        drive(18'd1, 19'h7FFFB, 18'd20, 18'd2, 19'h3FFFF, 18'd1, 3'd0, 3'd0, 0, 0, 0, 0, 64'd0, "R7 pre-add wrap");
        drive(18'd2, 19'd1, 18'd0, 18'd3, 19'd1, 18'd0, 3'd7, 3'd6, 0, 0, 0, 0, 64'd0, "R8 coef 7/6");
        drive(18'd3, 19'd1, 18'd0, 18'd4, 19'd1, 18'd0, 3'd6, 3'd7, 1, 0, 0, 0, 64'd0, "R8 coef 6/7");
        for (int i = 0; i < 60; i++)
            drive(18'($urandom), 19'($urandom), 18'($urandom), 18'($urandom),
                  19'($urandom), 18'($urandom), 3'($urandom), 3'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0,
                  {$urandom, $urandom}, "R2/R5/R6 random");
        @(negedge clk);
        top_x = '0; top_y = '0; top_z = '0; bot_x = '0; bot_y = '0; bot_z = '0;
        op_sub = 0; op_neg = 0; op_acc = 0; op_ld = 0; chain_in = '0;
        while (sb.size() > 0) @(negedge clk);

        // Directed: stage holds and the split clear.
        repeat (3) @(negedge clk);
        chain_in = 64'd5;
        repeat (3) @(negedge clk);
        chk(res_a == 64'd5, "R2 chain pass", res_a, 64'd5);
        en_out = 1'b0; chain_in = 64'd9;
        repeat (4) @(negedge clk);
        chk(res_a == 64'd5, "R10 output hold", res_a, 64'd5);
        en_out = 1'b1;
        @(negedge clk);
        chk(res_a == 64'd9, "R10 output resume", res_a, 64'd9);
        top_x = 18'd1234;
        @(negedge clk);
        chk(scan_a == 18'd1234, "R9 scan_out", 64'(scan_a), 64'd1234);
        rst_pipe_n = 1'b0;
        @(negedge clk);
        chk(res_a == '0, "R11 pipe clear result", res_a, 64'd0);
        chk(scan_a == 18'd1234, "R11 input stage kept", 64'(scan_a), 64'd1234);
        rst_pipe_n = 1'b1;
        en_in = 1'b0; top_x = 18'd77;
        repeat (2) @(negedge clk);
        chk(scan_a == 18'd1234, "R10 input hold", 64'(scan_a), 64'd1234);
        en_in = 1'b1;
        @(negedge clk);
        chk(scan_a == 18'd77, "R10 input resume", 64'(scan_a), 64'd77);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule